// File: doc/BRIEF.md
# Power-on Configuration Loader

At power-on the loader fills a bank of sequencer execution registers in two stages. First it reads every register's default value from a one-time-programmable store through a synchronous read port with one cycle of read latency. Then it may override part of the bank from an external EEPROM. The EEPROM is reached through a byte-read port that uses a request and acknowledge handshake, and a complete I2C master sits behind that port.

The override runs only when the EEPROM responds and the byte at a fixed signature address holds the expected value. If both hold, the EEPROM bytes from one past the signature address up to a stop address are written into the registers of the same index. Every other register keeps its OTP default. A three-bit status word records whether the EEPROM answered, whether the signature matched and whether the override copy ran to its end. A done output tells the power-up sequencer that it may start using the registers.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held and afterwards until `start` is seen, `done` is 0, `cfgStatus` is 000, every configuration register is 0, and neither `otpRdEn` nor `eeReq` is asserted.
- R2: After `start`, the block issues exactly NUM_REGS OTP reads with addresses 0, 1, ... NUM_REGS-1 in that order. The data returned one cycle after each read is stored in the register whose index equals the read address.
- R3: No EEPROM request is made before the last OTP read has been issued, and the two ports are never active in the same cycle.
- R4: The first EEPROM request reads address SIG_ADDR. If `eeNack` answers it, the load ends with `cfgStatus` = 000 and all registers holding their OTP values.
- R5: If the signature byte is acknowledged but differs from SIG_VALUE, the load ends with `cfgStatus` = 001 and no register is changed from its OTP value.
- R6: If the signature matches, EEPROM addresses SIG_ADDR+1 through STOP_ADDR are read in ascending order. Each acknowledged byte is written to the register with the same index, registers outside that range keep their OTP values, and the load ends with `cfgStatus` = 111.
- R7: While `eeReq` is high and neither `eeAck` nor `eeNack` has been seen, `eeAddr` stays unchanged.
- R8: An `eeNack` during the override copy stops the load. Bytes already written stay in place, the rest keep their OTP values, and `cfgStatus` = 011.
- R9: `done` rises once loading ends and stays high until reset. While `done` is high, `start` is ignored. Reset returns the block to idle, so a later `start` runs a full new load.
- R10: Status encoding is bit 0 = EEPROM answered, bit 1 = signature matched, bit 2 = copy finished. A set bit 2 implies bit 1, and a set bit 1 implies bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load from idle |
| otpRdEn | output | 1 | OTP read strobe |
| otpAddr | output | IDX_W | OTP read address |
| otpData | input | DATA_W | OTP read data, valid one cycle after the strobe |
| eeReq | output | 1 | EEPROM byte read request, held until answered |
| eeAddr | output | EE_ADDR_W | EEPROM byte address |
| eeAck | input | 1 | One-cycle pulse: byte read succeeded, `eeData` valid |
| eeNack | input | 1 | One-cycle pulse: EEPROM did not respond |
| eeData | input | DATA_W | EEPROM read data |
| cfgRegs | output | NUM_REGS*DATA_W | Execution registers, register i at bits i*DATA_W upward |
| cfgStatus | output | 3 | Present, match and copy-done flags |
| done | output | 1 | Loading finished |

## Verification
The load is tried with four EEPROM behaviours: no response, a wrong signature, a good signature with a full copy, and a good signature followed by a refusal partway through the copy. Each run uses a different OTP and EEPROM data seed and a different handshake latency. Comparing every register against its OTP or EEPROM value shows whether the override is gated correctly and whether the copy writes the right index range and stops at the right place. The status word tells the four endings apart. Zero-latency acknowledges test back-to-back requests, and slow acknowledges test that the address is held while a request waits.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_OTP_COPY = 3'd1,
    ST_EE_SIG   = 3'd2,
    ST_EE_COPY  = 3'd3,
    ST_DONE     = 3'd4
  } loadState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStatus;
    logic otpCapture;
    logic eeWrite;
    logic setPresent;
    logic setMatch;
    logic setCopyDone;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int DATA_W    = 8,
  parameter int EE_ADDR_W = 8,
  parameter int SIG_ADDR  = 3,
  parameter int STOP_ADDR = 11,
  parameter logic [DATA_W-1:0] SIG_VALUE = 8'hA5,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 otpRdEn,
  output logic [IDX_W-1:0]     otpAddr,
  output logic                 eeReq,
  output logic [EE_ADDR_W-1:0] eeAddr,
  input  logic                 eeAck,
  input  logic                 eeNack,
  input  logic [DATA_W-1:0]    eeData,
  output dpStrobe_t            strobe,
  output logic [IDX_W-1:0]     eeWrIdx,
  output logic                 done
);

  localparam logic [IDX_W-1:0]     LAST_IDX  = IDX_W'(NUM_REGS - 1);
  localparam logic [EE_ADDR_W-1:0] SIG_A     = EE_ADDR_W'(SIG_ADDR);
  localparam logic [EE_ADDR_W-1:0] FIRST_A   = EE_ADDR_W'(SIG_ADDR + 1);
  localparam logic [EE_ADDR_W-1:0] STOP_A    = EE_ADDR_W'(STOP_ADDR);

  loadState_e state;
  logic [IDX_W-1:0]     otpIdx;
  logic [EE_ADDR_W-1:0] eeIdx;
  logic sigOk;
  logic atStop;

  assign sigOk  = (eeData == SIG_VALUE);
  assign atStop = (eeIdx == STOP_A);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      otpIdx <= '0;
      eeIdx  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_OTP_COPY;
          otpIdx <= '0;
        end
        ST_OTP_COPY: begin
          if (otpIdx == LAST_IDX) begin
            state <= ST_EE_SIG;
            eeIdx <= SIG_A;
          end else begin
            otpIdx <= otpIdx + 1'b1;
          end
        end
        ST_EE_SIG: begin
          if (eeNack) state <= ST_DONE;
          else if (eeAck) begin
            if (sigOk) begin
              state <= ST_EE_COPY;
              eeIdx <= FIRST_A;
            end else begin
              state <= ST_DONE;
            end
          end
        end
        ST_EE_COPY: begin
          if (eeNack) state <= ST_DONE;
          else if (eeAck) begin
            if (atStop) state <= ST_DONE;
            else        eeIdx <= eeIdx + 1'b1;
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    otpRdEn = (state == ST_OTP_COPY);
    otpAddr = otpIdx;
    eeReq   = (state == ST_EE_SIG) || (state == ST_EE_COPY);
    eeAddr  = eeIdx;
    eeWrIdx = eeIdx[IDX_W-1:0];
    done    = (state == ST_DONE);

    strobe             = '0;
    strobe.clrStatus   = (state == ST_IDLE) && start;
    strobe.otpCapture  = (state == ST_OTP_COPY);
    strobe.setPresent  = (state == ST_EE_SIG) && eeAck && !eeNack;
    strobe.setMatch    = (state == ST_EE_SIG) && eeAck && !eeNack && sigOk;
    strobe.eeWrite     = (state == ST_EE_COPY) && eeAck && !eeNack;
    strobe.setCopyDone = (state == ST_EE_COPY) && eeAck && !eeNack && atStop;
  end

  // R9: once finished, stay finished until reset
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R3: the two read ports are never used together
  a_r3_one_port: assert property (@(posedge clk) disable iff (!rstN)
    !(otpRdEn && eeReq));

  // R7: a pending EEPROM request keeps its address
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (eeReq && !eeAck && !eeNack) |=> (eeReq && $stable(eeAddr)));

  // R6: EEPROM addresses stay within signature .. stop
  a_r6_addr_window: assert property (@(posedge clk) disable iff (!rstN)
    eeReq |-> (eeAddr >= SIG_A && eeAddr <= STOP_A));

  // R9: nothing is requested after completion
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!eeReq && !otpRdEn));

endmodule

// File: rtl/cfg_loader_dpath.sv
module cfg_loader_dpath
  import cfg_loader_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [IDX_W-1:0]           otpAddr,
  input  logic [DATA_W-1:0]          otpData,
  input  logic [IDX_W-1:0]           eeWrIdx,
  input  logic [DATA_W-1:0]          eeData,
  output logic [NUM_REGS*DATA_W-1:0] cfgRegs,
  output logic [2:0]                 cfgStatus
);

  // OTP data arrives one cycle after the read strobe
  logic             capPend;
  logic [IDX_W-1:0] capIdx;
  logic             stPresent, stMatch, stCopyDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capPend <= 1'b0;
      capIdx  <= '0;
    end else begin
      capPend <= strobe.otpCapture;
      capIdx  <= otpAddr;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      logic [DATA_W-1:0] value;
      logic otpHit, eeHit;
      assign otpHit = capPend && (capIdx == IDX_W'(gi));
      assign eeHit  = strobe.eeWrite && (eeWrIdx == IDX_W'(gi));
      always_ff @(posedge clk) begin
        if (!rstN)       value <= '0;
        else if (otpHit) value <= otpData;
        else if (eeHit)  value <= eeData;
      end
      assign cfgRegs[gi*DATA_W +: DATA_W] = value;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrStatus) begin
      stPresent  <= 1'b0;
      stMatch    <= 1'b0;
      stCopyDone <= 1'b0;
    end else begin
      if (strobe.setPresent)  stPresent  <= 1'b1;
      if (strobe.setMatch)    stMatch    <= 1'b1;
      if (strobe.setCopyDone) stCopyDone <= 1'b1;
    end
  end

  assign cfgStatus = {stCopyDone, stMatch, stPresent};

  // R10: status flags form a chain
  a_r10_copy_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    stCopyDone |-> stMatch);
  a_r10_match_needs_present: assert property (@(posedge clk) disable iff (!rstN)
    stMatch |-> stPresent);

  // R5: no override write without an accepted signature
  a_r5_write_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    strobe.eeWrite |-> stMatch);

  // R3: OTP capture never collides with an EEPROM write
  a_r3_no_write_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(capPend && strobe.eeWrite));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int DATA_W    = 8,
  parameter int EE_ADDR_W = 8,
  parameter int SIG_ADDR  = 3,
  parameter int STOP_ADDR = 11,
  parameter logic [DATA_W-1:0] SIG_VALUE = 8'hA5,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  output logic                       otpRdEn,
  output logic [IDX_W-1:0]           otpAddr,
  input  logic [DATA_W-1:0]          otpData,
  output logic                       eeReq,
  output logic [EE_ADDR_W-1:0]       eeAddr,
  input  logic                       eeAck,
  input  logic                       eeNack,
  input  logic [DATA_W-1:0]          eeData,
  output logic [NUM_REGS*DATA_W-1:0] cfgRegs,
  output logic [2:0]                 cfgStatus,
  output logic                       done
);

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] eeWrIdx;

  cfg_loader_ctrl #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .EE_ADDR_W(EE_ADDR_W),
    .SIG_ADDR(SIG_ADDR), .STOP_ADDR(STOP_ADDR), .SIG_VALUE(SIG_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .otpRdEn(otpRdEn), .otpAddr(otpAddr),
    .eeReq(eeReq), .eeAddr(eeAddr), .eeAck(eeAck), .eeNack(eeNack),
    .eeData(eeData), .strobe(strobe), .eeWrIdx(eeWrIdx), .done(done)
  );

  cfg_loader_dpath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .otpAddr(otpAddr), .otpData(otpData),
    .eeWrIdx(eeWrIdx), .eeData(eeData),
    .cfgRegs(cfgRegs), .cfgStatus(cfgStatus)
  );

endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;

  localparam int NUM_REGS  = 16;
  localparam int DATA_W    = 8;
  localparam int EE_ADDR_W = 8;
  localparam int SIG_ADDR  = 3;
  localparam int STOP_ADDR = 11;
  localparam logic [7:0] SIG_VALUE = 8'hA5;
  localparam int NACK_AT   = 7;
  localparam int IDX_W     = $clog2(NUM_REGS);

  // mode: 0 no EEPROM, 1 bad signature, 2 full copy, 3 refusal at NACK_AT
  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] delay;
    logic [7:0] seed;
    logic [2:0] expStatus;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 4'd0, 8'h11, 3'b000},
    '{2'd1, 4'd2, 8'h20, 3'b001},
    '{2'd2, 4'd0, 8'h33, 3'b111},
    '{2'd2, 4'd5, 8'h47, 3'b111},
    '{2'd3, 4'd1, 8'h58, 3'b011},
    '{2'd0, 4'd7, 8'h6A, 3'b000},
    '{2'd1, 4'd0, 8'h7C, 3'b001}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic otpRdEn;
  logic [IDX_W-1:0] otpAddr;
  logic [DATA_W-1:0] otpData = '0;
  logic eeReq;
  logic [EE_ADDR_W-1:0] eeAddr;
  logic eeAck = 1'b0, eeNack = 1'b0;
  logic [DATA_W-1:0] eeData = '0;
  logic [NUM_REGS*DATA_W-1:0] cfgRegs;
  logic [2:0] cfgStatus;
  logic done;

  always #10 clk = ~clk;

  cfg_loader #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .EE_ADDR_W(EE_ADDR_W),
    .SIG_ADDR(SIG_ADDR), .STOP_ADDR(STOP_ADDR), .SIG_VALUE(SIG_VALUE)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .otpRdEn(otpRdEn), .otpAddr(otpAddr), .otpData(otpData),
    .eeReq(eeReq), .eeAddr(eeAddr), .eeAck(eeAck), .eeNack(eeNack),
    .eeData(eeData), .cfgRegs(cfgRegs), .cfgStatus(cfgStatus), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  logic [1:0] mMode  = 2'd0;
  logic [3:0] mDelay = 4'd0;
  logic [7:0] mSeed  = 8'h00;

  function automatic logic [7:0] otpVal(int a, logic [7:0] s);
    return 8'(a * 7 + 1) + s;
  endfunction
  function automatic logic [7:0] eeVal(int a, logic [7:0] s);
    return (8'(a) ^ 8'h3C) + s;
  endfunction
  function automatic logic [7:0] expReg(int i, logic [1:0] m, logic [7:0] s);
    if ((m == 2'd2 || (m == 2'd3 && i < NACK_AT)) && i > SIG_ADDR && i <= STOP_ADDR)
      return eeVal(i, s);
    return otpVal(i, s);
  endfunction

  // OTP model: one cycle read latency
  always_ff @(posedge clk)
    if (otpRdEn) otpData <= otpVal(int'(otpAddr), mSeed);

  // EEPROM model: answers after mDelay waiting cycles
  int eeCnt = 0;
  always_ff @(posedge clk) begin
    if (eeAck || eeNack) begin
      eeAck <= 1'b0; eeNack <= 1'b0; eeCnt <= 0;
    end else if (eeReq) begin
      if (eeCnt >= int'(mDelay)) begin
        eeCnt <= 0;
        if (mMode == 2'd0 || (mMode == 2'd3 && int'(eeAddr) == NACK_AT)) begin
          eeNack <= 1'b1;
        end else begin
          eeAck <= 1'b1;
          if (int'(eeAddr) == SIG_ADDR)
            eeData <= (mMode == 2'd1) ? (SIG_VALUE ^ 8'hFF) : SIG_VALUE;
          else
            eeData <= eeVal(int'(eeAddr), mSeed);
        end
      end else begin
        eeCnt <= eeCnt + 1;
      end
    end
  end

  // port monitors, sampled on the falling edge
  int otpReads = 0, otpOrderErr = 0, earlyEe = 0, addrMoved = 0;
  logic prevPend = 1'b0;
  logic [EE_ADDR_W-1:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (otpRdEn) begin
        if (int'(otpAddr) != otpReads) otpOrderErr++;
        otpReads++;
      end
      if (eeReq && otpReads != NUM_REGS) earlyEe++;
      if (prevPend && eeReq && eeAddr != prevAddr) addrMoved++;
      prevPend = eeReq && !eeAck && !eeNack;
      prevAddr = eeAddr;
    end else begin
      prevPend = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    otpReads = 0; otpOrderErr = 0; earlyEe = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runLoad(output bit ok);
    int t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 2000) begin
      @(negedge clk);
      t++;
    end
    ok = done;
  endtask

  task automatic checkRegs(input string req, input logic [1:0] m, input logic [7:0] s);
    for (int i = 0; i < NUM_REGS; i++)
      chk(cfgRegs[i*DATA_W +: DATA_W] == expReg(i, m, s), req,
          64'(cfgRegs[i*DATA_W +: DATA_W]), 64'(expReg(i, m, s)));
  endtask

  bit finished = 1'b0;
  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit ok;
    logic [NUM_REGS*DATA_W-1:0] snap;
    // R1: reset state
    doReset();
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    chk(cfgStatus == 3'b000, "R1 status", 64'(cfgStatus), 64'd0);
    chk(cfgRegs == '0, "R1 regs", 64'(cfgRegs[63:0]), 64'd0);
    chk(!otpRdEn && !eeReq, "R1 ports idle", 64'({otpRdEn, eeReq}), 64'd0);

    // vector table: R2 R4 R5 R6 R8 R10
    for (int v = 0; v < NVEC; v++) begin
      mMode = VECS[v].mode; mDelay = VECS[v].delay; mSeed = VECS[v].seed;
      doReset();
      runLoad(ok);
      chk(ok, "R9 done rises", 64'(ok), 64'd1);
      chk(cfgStatus == VECS[v].expStatus, "R4/R5/R6/R8/R10 status",
          64'(cfgStatus), 64'(VECS[v].expStatus));
      case (VECS[v].mode)
        2'd0: checkRegs("R4 regs", mMode, mSeed);
        2'd1: checkRegs("R5 regs", mMode, mSeed);
        2'd2: checkRegs("R6 regs", mMode, mSeed);
        default: checkRegs("R8 regs", mMode, mSeed);
      endcase
      chk(otpReads == NUM_REGS && otpOrderErr == 0, "R2 otp reads",
          64'(otpReads), 64'(NUM_REGS));
      chk(earlyEe == 0, "R3 ee before otp end", 64'(earlyEe), 64'd0);
    end

    // R9: start ignored after completion
    snap = cfgRegs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk(otpReads == NUM_REGS, "R9 start ignored reads", 64'(otpReads), 64'(NUM_REGS));
    chk(cfgRegs == snap && done, "R9 regs kept", 64'(cfgRegs[63:0]), 64'(snap[63:0]));

    // R9: reset returns to idle and a new load runs
    mMode = 2'd2; mDelay = 4'd3; mSeed = 8'h90;
    doReset();
    chk(done == 1'b0, "R9 done cleared by reset", 64'(done), 64'd0);
    runLoad(ok);
    chk(cfgStatus == 3'b111, "R9 rerun status", 64'(cfgStatus), 64'b111);
    checkRegs("R9 rerun regs", mMode, mSeed);

    // R7: address held while waiting
    chk(addrMoved == 0, "R7 addr held", 64'(addrMoved), 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule